// File: doc/BRIEF.md
# Multi-source interrupt latch controller

This block gathers several interrupt sources from a 24-line digital I/O block and an external counter and folds them into one latched interrupt request. The lines form three 8-bit ports. Each port can raise the interrupt when any of its lines changes level, in either direction. Two further sources raise it on a rising edge: one line of the third port, and the counter output. An active-low hardware pin gates every source.

Software controls the block through byte-wide registers. It can enable or disable each source, disable all sources with one write, clear the latched request, and read back the enables, the synchronized pin level and the latched state. Every monitored input passes through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it. Once set, the request stays high until software clears it.

Top module: `irq_gather`

## Requirements
- R1: After reset, `irq_o` is 0, the register at offset 0xB reads 0x07 and bits 1:0 of the register at offset 0xE read 0.
- R2: Offset 0xB holds one disable bit per port: bit 0 for port A (`lines_i[7:0]`), bit 1 for port B (`lines_i[15:8]`) and bit 2 for port C (`lines_i[23:16]`). Writing 0 enables change detection for that port and writing 1 disables it. Bits 7:3 always read 0.
- R3: While a port's change detection is enabled, a level change in either direction on any of its lines latches `irq_o`. Changes on a disabled port leave `irq_o` unchanged.
- R4: While bit 0 of offset 0xE is 1, a rising edge on port C bit 3 (`lines_i[19]`) latches `irq_o`. A falling edge on that line does not.
- R5: While bit 1 of offset 0xE is 1, a rising edge on `ctr_i` latches `irq_o`. A falling edge does not.
- R6: Offset 0xE bit 4 reads the synchronized level of `gate_pin_i`, and bit 5 reads the current value of `irq_o`. Bits 7:6 and 3:2 read 0.
- R7: While the synchronized `gate_pin_i` is 0, no source can set `irq_o`.
- R8: A write of any value to offset 0xD sets offset 0xB to 0x07 and clears bits 1:0 of offset 0xE.
- R9: A write of any value to offset 0xF clears `irq_o`. Without such a write, `irq_o` stays 1 once it is set.
- R10: If a qualifying event occurs in the same cycle as a clear write, `irq_o` stays 1.
- R11: An input change that qualifies sets `irq_o` on the third rising clock edge after the change, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines_i | input | 24 | I/O line levels: port A in 7:0, port B in 15:8, port C in 23:16 |
| ctr_i | input | 1 | Counter output level |
| gate_pin_i | input | 1 | Hardware enable pin; low blocks every source |
| wr_en_i | input | 1 | Register write strobe for one cycle |
| addr_i | input | 5 | Register offset, used for both read and write |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Read data for the register at `addr_i` (combinational) |
| irq_o | output | 1 | Latched interrupt request |

## Verification
The bench walks sequences in which each port is enabled alone, so that a design that wired the disable bits to the wrong port would fire on a disabled port or stay silent on an enabled one. It toggles port C bit 3 and the counter in both directions, which catches edge detection that reacts to falling edges as well. It writes a clear in the exact cycle an event arrives: a design that gave the clear priority would drop an interrupt there. It also samples the request one edge before and on the edge the two synchronizer stages allow, to catch a missing or extra stage. It checks that the global-disable write forces the enable state without any help from the data bus and that a low gate pin stops a counter edge that arrives at the same time.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  // register offsets; host software decodes these
  localparam logic [4:0] OFS_COS  = 5'h0B;
  localparam logic [4:0] OFS_GDIS = 5'h0D;
  localparam logic [4:0] OFS_EDGE = 5'h0E;
  localparam logic [4:0] OFS_CLR  = 5'h0F;

  // bit positions inside the edge register
  localparam int EB_C3   = 0;
  localparam int EB_CTR  = 1;
  localparam int EB_PIN  = 4;
  localparam int EB_IRQ  = 5;

  // any bit differs between two samples
  function automatic logic any_toggle(input logic [31:0] cur, input logic [31:0] prv);
    return |(cur ^ prv);
  endfunction

  // low-to-high step between two samples
  function automatic logic rose(input logic cur, input logic prv);
    return cur & ~prv;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
  import irq_gather_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int PORT_W  = 8,
  parameter int C3_IDX  = 19,
  localparam int LINE_W = N_PORTS * PORT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  lines_s,
  input  logic               ctr_s,
  input  logic               pin_s,
  input  logic [N_PORTS-1:0] cos_on,
  input  logic [1:0]         edge_en,
  output logic [N_PORTS-1:0] port_chg,
  output logic               c3_rise,
  output logic               ctr_rise,
  output logic               evt
);
  logic [LINE_W-1:0] lines_prev;
  logic              ctr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_prev <= '0;
      ctr_prev   <= 1'b0;
    end else begin
      lines_prev <= lines_s;
      ctr_prev   <= ctr_s;
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign port_chg[p] = any_toggle(32'(lines_s[p*PORT_W +: PORT_W]),
                                    32'(lines_prev[p*PORT_W +: PORT_W]));
  end

  assign c3_rise  = rose(lines_s[C3_IDX], lines_prev[C3_IDX]);
  assign ctr_rise = rose(ctr_s, ctr_prev);

  assign evt = pin_s & ((|(port_chg & cos_on))
                        | (edge_en[0] & c3_rise)
                        | (edge_en[1] & ctr_rise));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_gather_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               irq,
  input  logic               pin_s,
  output logic [N_PORTS-1:0] cos_dis,
  output logic [1:0]         edge_en,
  output logic               clr_wr,
  output logic               dis_wr,
  output logic [DATA_W-1:0]  rd_data
);
  logic cos_wr, edge_wr;
  logic unused_wr;

  assign cos_wr    = wr_en && (addr == ADDR_W'(OFS_COS));
  assign edge_wr   = wr_en && (addr == ADDR_W'(OFS_EDGE));
  assign dis_wr    = wr_en && (addr == ADDR_W'(OFS_GDIS));
  assign clr_wr    = wr_en && (addr == ADDR_W'(OFS_CLR));
  assign unused_wr = ^wr_data[DATA_W-1:N_PORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_dis <= '1;
      edge_en <= '0;
    end else if (dis_wr) begin
      cos_dis <= '1;
      edge_en <= '0;
    end else begin
      if (cos_wr)  cos_dis <= wr_data[N_PORTS-1:0];
      if (edge_wr) edge_en <= wr_data[1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFS_COS)) begin
      rd_data[N_PORTS-1:0] = cos_dis;
    end else if (addr == ADDR_W'(OFS_EDGE)) begin
      rd_data[EB_C3]  = edge_en[0];
      rd_data[EB_CTR] = edge_en[1];
      rd_data[EB_PIN] = pin_s;
      rd_data[EB_IRQ] = irq;
    end
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int PORT_W  = 8,
  parameter int C3_PORT = 2,
  parameter int C3_BIT  = 3,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS*PORT_W-1:0]   lines_i,
  input  logic                        ctr_i,
  input  logic                        gate_pin_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        irq_o
);
  localparam int LINE_W = N_PORTS * PORT_W;
  localparam int C3_IDX = C3_PORT * PORT_W + C3_BIT;
  localparam int SYN_W  = LINE_W + 2;
  // gate pin resets high, matching its pulled-up idle level
  localparam logic [SYN_W-1:0] SYN_RST = {1'b1, 1'b0, {LINE_W{1'b0}}};

  logic [SYN_W-1:0]   syn_q;
  logic [LINE_W-1:0]  lines_s;
  logic               ctr_s, pin_s;
  logic [N_PORTS-1:0] cos_dis, port_chg;
  logic [1:0]         edge_en;
  logic               clr_wr, dis_wr, c3_rise, ctr_rise, evt;

  irq_sync #(.W(SYN_W), .RST(SYN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({gate_pin_i, ctr_i, lines_i}),
    .q(syn_q)
  );

  assign lines_s = syn_q[LINE_W-1:0];
  assign ctr_s   = syn_q[LINE_W];
  assign pin_s   = syn_q[LINE_W+1];

  irq_regs #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .addr(addr_i), .wr_data(wr_data_i),
    .irq(irq_o), .pin_s(pin_s),
    .cos_dis(cos_dis), .edge_en(edge_en),
    .clr_wr(clr_wr), .dis_wr(dis_wr),
    .rd_data(rd_data_o)
  );

  irq_src_detect #(.N_PORTS(N_PORTS), .PORT_W(PORT_W), .C3_IDX(C3_IDX)) u_det (
    .clk(clk), .rst_n(rst_n),
    .lines_s(lines_s), .ctr_s(ctr_s), .pin_s(pin_s),
    .cos_on(~cos_dis), .edge_en(edge_en),
    .port_chg(port_chg), .c3_rise(c3_rise), .ctr_rise(ctr_rise),
    .evt(evt)
  );

  // event has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_o <= 1'b0;
    else if (evt)    irq_o <= 1'b1;
    else if (clr_wr) irq_o <= 1'b0;
  end
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               evt,
  input logic               clr_wr,
  input logic               dis_wr,
  input logic               pin_s,
  input logic [N_PORTS-1:0] cos_dis,
  input logic [1:0]         edge_en,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rd_data_o
);
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !evt) |=> !irq_o); // R3
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq_o); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_wr) |=> irq_o); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !evt) |=> !irq_o); // R9
  AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |-> !evt); // R7
  AST_GDIS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (cos_dis == '1 && edge_en == 2'b00)); // R8
  AST_COS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(5'h0B)) |-> (rd_data_o[DATA_W-1:N_PORTS] == '0)); // R2
  AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(5'h0E)) |-> (rd_data_o[5] == irq_o)); // R6
endmodule

bind irq_gather irq_gather_chk #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .evt(evt), .clr_wr(clr_wr),
  .dis_wr(dis_wr), .pin_s(pin_s), .cos_dis(cos_dis), .edge_en(edge_en),
  .addr_i(addr_i), .rd_data_o(rd_data_o)
);

// File: tb/sim_irq_gather.sv
`timescale 1ns/1ps
module sim_irq_gather;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] lines = '0;
  logic        ctr = 1'b0;
  logic        pin = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          checks = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_gather u0 (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .ctr_i(ctr), .gate_pin_i(pin),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  a;
    logic [7:0]  d;
    logic [23:0] ln;
    logic        ct;
    logic        pn;
    logic        ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h00, 8'h00, 24'h000001, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 all disabled after reset
    '{1'b1, 5'h0B, 8'h06, 24'h000001, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 enable A, no change
    '{1'b0, 5'h00, 8'h00, 24'h000000, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 A bit0 falls
    '{1'b1, 5'h0F, 8'h00, 24'h000000, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 clear
    '{1'b0, 5'h00, 8'h00, 24'h000100, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 B disabled
    '{1'b1, 5'h0B, 8'h03, 24'h800100, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 C only, C7 rises
    '{1'b1, 5'h0F, 8'hFF, 24'h800100, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 clear any value
    '{1'b1, 5'h0B, 8'h07, 24'h000100, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 all disabled
    '{1'b1, 5'h0E, 8'h01, 24'h080100, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 C3 rises
    '{1'b1, 5'h0F, 8'h00, 24'h080100, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 5'h00, 8'h00, 24'h000100, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 C3 falls
    '{1'b1, 5'h0E, 8'h02, 24'h000100, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 counter rises
    '{1'b1, 5'h0F, 8'h00, 24'h000100, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 5'h00, 8'h00, 24'h000100, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 counter falls
    '{1'b0, 5'h00, 8'h00, 24'h000100, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 pin low blocks
    '{1'b0, 5'h00, 8'h00, 24'h000100, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 pin back, no edge
    '{1'b1, 5'h0D, 8'h5A, 24'h000100, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 global disable
    '{1'b0, 5'h00, 8'h00, 24'h000100, 1'b1, 1'b1, 1'b0, 4'd8}   // R8 counter edge ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // reset state
    check("R1 irq after reset", 32'(irq), 32'd0);
    rd(5'h0B, v); check("R1 cos reg after reset", 32'(v), 32'h07);
    rd(5'h0E, v); check("R6 edge reg after reset, pin high", 32'(v), 32'h10);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].wr; addr = VEC[i].a; wdata = VEC[i].d;
      lines = VEC[i].ln; ctr = VEC[i].ct; pin = VEC[i].pn;
      @(negedge clk);
      wr_en = 1'b0;
      idle(3);
      check($sformatf("R%0d vector %0d irq", VEC[i].rq, i), 32'(irq), 32'(VEC[i].ex));
    end

    // R8: global disable forces enables regardless of data
    wr(5'h0B, 8'h00);
    wr(5'h0E, 8'h03);
    wr(5'h0D, 8'h00);
    rd(5'h0B, v); check("R8 cos reg after global disable", 32'(v), 32'h07);
    rd(5'h0E, v); check("R8 edge enables after global disable", 32'(v[1:0]), 32'd0);

    // R2/R6: padding bits read zero
    wr(5'h0B, 8'hF8);
    rd(5'h0B, v); check("R2 cos reg padding", 32'(v), 32'h00);
    wr(5'h0E, 8'hFF);
    rd(5'h0E, v); check("R6 edge reg readback", 32'(v), 32'h13);
    wr(5'h0D, 8'hFF);

    // R6: pin level readback when low
    pin = 1'b0;
    idle(3);
    rd(5'h0E, v); check("R6 pin low readback", 32'(v), 32'h00);
    pin = 1'b1;
    idle(3);

    // R11: synchronizer latency, port A enabled
    wr(5'h0B, 8'h06);
    idle(2);
    @(negedge clk);
    lines[5] = ~lines[5];
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 irq not yet after two edges", 32'(irq), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R11 irq on third edge", 32'(irq), 32'd1);
    rd(5'h0E, v); check("R6 irq bit read", 32'(v[5]), 32'd1);

    // R9: holds without clear
    idle(20);
    check("R9 irq holds", 32'(irq), 32'd1);
    wr(5'h0F, 8'h33);
    idle(1);
    check("R9 irq cleared", 32'(irq), 32'd0);

    // R10: event coincides with clear
    @(negedge clk);
    lines[2] = ~lines[2];
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'h0F; wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 event wins over clear", 32'(irq), 32'd1);
    wr(5'h0F, 8'h00);
    idle(1);
    check("R9 clear after R10", 32'(irq), 32'd0);

    // R7: pin low blocks a port change
    pin = 1'b0;
    idle(3);
    lines[1] = ~lines[1];
    idle(5);
    check("R7 port change blocked by pin", 32'(irq), 32'd0);
    pin = 1'b1;
    idle(4);
    check("R7 no late event after pin returns", 32'(irq), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule